// File: doc/BRIEF.md
# Pin-Change Interrupt GPIO Port

This block is an eight-pin general-purpose I/O port with a small register interface for a host. The host sets the direction of each pin, sets an output latch, reads back the levels seen on the pins, and chooses which input pins may raise an interrupt when their level changes. Each pin has a separate output value and output enable, which the pad ring combines into a tri-state driver. The pad level comes back on a separate input.

Pin inputs pass through a two-stage synchronizer. A pin that is configured as an input and whose synchronized level differs from its value one cycle earlier sets a sticky pending flag, provided that pin's change interrupt is enabled. The interrupt output is the OR of all pending flags. Reading the state register clears every pending flag, and so does any write to the direction register. When the modem-mode input is high, the upper four pins do not use their own enable bits. A single external enable input gates their change interrupts instead.

Top module: `gpio_chg_port`

## Requirements
- R1: `pin_oe[n]` follows bit n of the direction register (address 0). A 1 makes pin n an output and a 0 makes it an input.
- R2: A write to the state register (address 1) loads the output latch, and `pin_out` shows the latch. A read of address 1 returns the synchronized levels of all pins, whatever each pin's direction.
- R3: Register addresses are 0 for direction, 1 for state and 2 for interrupt enable. Address 3 reads as zero. `reg_rdata` is valid in the cycle after `reg_rd` and holds its value while no read is issued.
- R4: A change on `pin_in` is visible to a state read two clock edges later. A change on an enabled input pin raises `irq` on the third edge, and not before.
- R5: With interrupt-enable bit n (address 2) at 1, a level change on input pin n sets a pending flag. With bit n at 0, the change leaves `irq` unchanged.
- R6: A pin configured as an output never sets a pending flag, even when its enable bit is 1.
- R7: Pending flags are sticky. `irq` stays high until a state read clears all of the flags.
- R8: Any write to the direction register clears all pending flags, and `irq` is low in the following cycle.
- R9: While `modem_mode` is 1, change interrupts on pins 7 to 4 are gated by `modem_ie`, and enable bits 7 to 4 have no effect. Pins 3 to 0 keep their own enable bits.
- R10: After reset all pins are inputs, the output latch and all enable bits are 0, and `irq` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | 2 | Register address |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, valid one cycle after the strobe |
| pin_in | input | 8 | Levels sampled from the pads |
| pin_out | output | 8 | Output latch value for the pads |
| pin_oe | output | 8 | Per-pin output enable |
| modem_mode | input | 1 | Upper nibble is used for modem control |
| modem_ie | input | 1 | Global change-interrupt enable for the upper nibble in modem mode |
| irq | output | 1 | Level-sensitive interrupt request |

## Verification
The bench builds the port with its default parameters: eight pins, a modem boundary at pin 4 and two synchronizer stages. This makes the exact edge on which a change becomes visible predictable, so the bench can check both the edge before `irq` rises and the edge on which it rises. Because the modem boundary splits the port into two nibbles, each gating path can be tested separately. The bench toggles upper pins while their own enable bits disagree with `modem_ie`, and it checks that the lower pins keep their own enable bits while modem mode is on.

// File: rtl/gpio_chg_port.sv
module gpio_chg_port #(
  parameter int NPIN        = 8,
  parameter int MODEM_LSB   = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [1:0]      reg_addr,
  input  logic            reg_wr,
  input  logic            reg_rd,
  input  logic [NPIN-1:0] reg_wdata,
  output logic [NPIN-1:0] reg_rdata,
  input  logic [NPIN-1:0] pin_in,
  output logic [NPIN-1:0] pin_out,
  output logic [NPIN-1:0] pin_oe,
  input  logic            modem_mode,
  input  logic            modem_ie,
  output logic            irq
);
  localparam logic [NPIN-1:0] MODEM_MASK = {NPIN{1'b1}} << MODEM_LSB;

  logic [NPIN-1:0] dir_q, lat_q, ien_q, pend_q, prev_q;
  logic [NPIN-1:0] sync_q [SYNC_STAGES];
  logic [NPIN-1:0] pin_s, en_eff, chg;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sync_q[0] <= '0;
    else        sync_q[0] <= pin_in;

  for (genvar i = 1; i < SYNC_STAGES; i++) begin : g_sync
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) sync_q[i] <= '0;
      else        sync_q[i] <= sync_q[i-1];
  end

  assign pin_s = sync_q[SYNC_STAGES-1];

  wire wr_dir   = reg_wr && reg_addr == 2'd0;
  wire wr_state = reg_wr && reg_addr == 2'd1;
  wire wr_ien   = reg_wr && reg_addr == 2'd2;
  wire rd_state = reg_rd && reg_addr == 2'd1;

  assign en_eff = modem_mode ? ((ien_q & ~MODEM_MASK) | ({NPIN{modem_ie}} & MODEM_MASK))
                             : ien_q;
  assign chg    = (pin_s ^ prev_q) & ~dir_q & en_eff;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q     <= '0;
      lat_q     <= '0;
      ien_q     <= '0;
      pend_q    <= '0;
      prev_q    <= '0;
      reg_rdata <= '0;
    end else begin
      prev_q <= pin_s;
      if (wr_dir)   dir_q <= reg_wdata;
      if (wr_state) lat_q <= reg_wdata;
      if (wr_ien)   ien_q <= reg_wdata;
      if (wr_dir)        pend_q <= '0;
      else if (rd_state) pend_q <= chg;
      else               pend_q <= pend_q | chg;
      if (reg_rd) begin
        case (reg_addr)
          2'd0:    reg_rdata <= dir_q;
          2'd1:    reg_rdata <= pin_s;
          2'd2:    reg_rdata <= ien_q;
          default: reg_rdata <= '0;
        endcase
      end
    end
  end

  assign pin_oe  = dir_q;
  assign pin_out = lat_q;
  assign irq     = |pend_q;
endmodule

// File: rtl/gpio_chg_port_chk.sv
module gpio_chg_port_chk #(
  parameter int NPIN = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic [1:0]      reg_addr,
  input logic            reg_wr,
  input logic            reg_rd,
  input logic [NPIN-1:0] reg_wdata,
  input logic [NPIN-1:0] reg_rdata,
  input logic [NPIN-1:0] pin_out,
  input logic [NPIN-1:0] pin_oe,
  input logic            irq
);
  AST_OE_FOLLOWS_DIR: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 2'd0) |=> pin_oe == $past(reg_wdata)); // R1
  AST_LATCH_DRIVES_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 2'd1) |=> pin_out == $past(reg_wdata)); // R2
  AST_RDATA_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_rd |=> $stable(reg_rdata)); // R3
  AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !(reg_wr && reg_addr == 2'd0) && !(reg_rd && reg_addr == 2'd1)) |=> irq); // R7
  AST_DIRWR_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 2'd0) |=> !irq); // R8
endmodule

bind gpio_chg_port gpio_chg_port_chk #(.NPIN(NPIN)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
  .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pin_out(pin_out), .pin_oe(pin_oe),
  .irq(irq));

// File: tb/gpio_chg_port_bench.sv
`timescale 1ns/1ps
module gpio_chg_port_bench;
  logic       clk = 0, rst_n = 0;
  logic [1:0] reg_addr = 0;
  logic       reg_wr = 0, reg_rd = 0;
  logic [7:0] reg_wdata = 0, reg_rdata, pin_in = 0, pin_out, pin_oe;
  logic       modem_mode = 0, modem_ie = 0, irq;
  int vecs = 0, errs = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];
  logic       mon_go = 0;

  always #2.5 clk = ~clk;

  gpio_chg_port u_gpio_chg_port (.*);

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    vecs++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  always @(posedge clk) mon_go <= reg_rd;
  always @(negedge clk)
    if (mon_go) begin
      if (exp_q.size() == 0) chk("R3 unexpected read", 8'h00, 8'hFF);
      else chk(tag_q.pop_front(), reg_rdata, exp_q.pop_front());
    end

  task automatic cyc(int n); repeat (n) @(negedge clk); endtask
  task automatic wr(logic [1:0] a, logic [7:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1;
    @(negedge clk); reg_wr = 0;
  endtask
  task automatic rd(logic [1:0] a, logic [7:0] e, string tag);
    @(negedge clk); reg_addr = a; reg_rd = 1; exp_q.push_back(e); tag_q.push_back(tag);
    @(negedge clk); reg_rd = 0;
  endtask
  task automatic setpin(logic [7:0] v); @(negedge clk); pin_in = v; endtask

  initial begin
    #1000000;
    errs++; vecs++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    cyc(3); rst_n = 1;
    chk("R10 oe", pin_oe, 8'h00);
    chk("R10 out", pin_out, 8'h00);
    chk("R10 irq", {7'd0, irq}, 8'h00);
    rd(0, 8'h00, "R10 dir");
    rd(2, 8'h00, "R10 ien");
    rd(3, 8'h00, "R3 addr3");

    wr(0, 8'hF0); chk("R1 oe", pin_oe, 8'hF0);
    wr(1, 8'hA5); chk("R2 out", pin_out, 8'hA5);
    rd(0, 8'hF0, "R3 dir readback");

    setpin(8'h3C); cyc(2);
    rd(1, 8'h3C, "R2 R4 state read");
    chk("R5 disabled", {7'd0, irq}, 8'h00);

    wr(2, 8'h01); rd(2, 8'h01, "R3 ien readback");
    setpin(8'h3D); cyc(2);
    chk("R4 early", {7'd0, irq}, 8'h00);
    cyc(1);
    chk("R4 R5 raised", {7'd0, irq}, 8'h01);

    setpin(8'h3C); cyc(4);
    chk("R7 sticky", {7'd0, irq}, 8'h01);
    rd(1, 8'h3C, "R7 state");
    chk("R7 cleared", {7'd0, irq}, 8'h00);

    wr(2, 8'hFF);
    setpin(8'h0C); cyc(4);
    chk("R6 output pins", {7'd0, irq}, 8'h00);

    setpin(8'h0D); cyc(4);
    chk("R8 pre", {7'd0, irq}, 8'h01);
    wr(0, 8'hF0);
    chk("R8 dir write", {7'd0, irq}, 8'h00);
    cyc(3);
    chk("R8 stays", {7'd0, irq}, 8'h00);

    wr(0, 8'h00); wr(2, 8'h0F);
    @(negedge clk); modem_mode = 1; modem_ie = 1;
    setpin(8'h2D); cyc(4);
    chk("R9 global on", {7'd0, irq}, 8'h01);
    rd(1, 8'h2D, "R9 state");
    @(negedge clk); modem_ie = 0;
    wr(2, 8'hF0);
    setpin(8'h6D); cyc(4);
    chk("R9 global off", {7'd0, irq}, 8'h00);
    @(negedge clk); modem_mode = 0;
    setpin(8'h2D); cyc(4);
    chk("R9 own bits", {7'd0, irq}, 8'h01);
    rd(1, 8'h2D, "R9 state2");
    @(negedge clk); modem_mode = 1; modem_ie = 1;
    wr(2, 8'h00);
    setpin(8'h2C); cyc(4);
    chk("R9 lower nibble", {7'd0, irq}, 8'h00);

    cyc(2);
    chk("R3 queue drained", 8'(exp_q.size()), 8'h00);
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule